// File: doc/BRIEF.md
# Private Scratch Memory Address Generator

This block turns one scratch-memory access into a byte address. An access is described by a byte offset inside a thread's private area, a fiber (lane) index, a wavefront index and a processor index. Shared setup inputs give the per-item byte size, the total per-processor byte size and a base address. The layout select picks one of two interleavings. The wave-interleaved layout packs neighbouring fibers at dword granularity. The fiber-interleaved layout gives each fiber a contiguous slot of per-item size.

The fiber-interleaved layout can only serve single-dword accesses. A wider request made in that layout raises an error flag, and the block returns the wave-interleaved address for it. The base input moves the whole region; any hardware return stack placed after the normal per-processor areas is left to the caller. The result is registered, so it appears one clock after a valid request.

Top module: `pvt_addr_gen`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `out_valid`, `err_wide` and `addr_out` are all zero.
- R2: `out_valid` is high in exactly the cycles that follow a cycle with `in_valid` high.
- R3: With `layout_sel`=0 (wave-interleaved), `addr_out` = base + proc*proc_size + wave*item_size*128 + (off div 4)*512 + fiber*4 + (off mod 4), taken modulo 2^32.
- R4: With `layout_sel`=1 (fiber-interleaved) and `acc_len`=0, `addr_out` = base + proc*proc_size + ((fiber div 4)*NUM_WAVES*4 + wave*4 + fiber mod 4)*item_size + off, taken modulo 2^32.
- R5: With `layout_sel`=1 and `acc_len`≠0 (`acc_len` holds the access width in dwords minus one), `err_wide` goes high and `addr_out` holds the R3 address.
- R6: With `layout_sel`=0, `err_wide` is low for every `acc_len`, and the address does not depend on `acc_len`.
- R7: The processor index always adds processor*proc_size, whichever layout is selected.
- R8: In a cycle with `in_valid` low, `addr_out` and `err_wide` keep their previous values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| layout_sel | input | 1 | 0 wave-interleaved, 1 fiber-interleaved |
| acc_len | input | LEN_W | Access width in dwords minus one |
| byte_off | input | OFF_W | Byte offset in the thread's private area |
| fiber_id | input | FIBER_W | Fiber index, 0 to FIBERS-1 |
| wave_id | input | WAVE_W | Wavefront index |
| proc_id | input | PROC_W | Processor index |
| item_size | input | ITEM_W | Private bytes per item |
| proc_size | input | ADDR_W | Total private bytes per processor |
| base_addr | input | ADDR_W | Region base address |
| out_valid | output | 1 | Address valid |
| addr_out | output | ADDR_W | Computed byte address |
| err_wide | output | 1 | Multi-dword request in fiber-interleaved layout |

## Verification
The bench sweeps all 128 fibers against offsets that cross dword boundaries and reach the top of the offset range. It does this for several wavefronts and for processor indices 0 and 3, in both layouts and with two setups; the second setup makes the sum wrap past 2^32. A design that swaps the interleave order, or that uses the wrong fiber split in the fiber-interleaved slot, gives wrong addresses for fibers that are not multiples of four or for offsets at 4 and above. A design that drops the fallback for wide accesses, or that flags wide accesses in the wave layout, shows the wrong error flag or an address in the wrong layout. A design that loads its register while the request is idle changes the held address between requests.

// File: rtl/pvt_pkg.sv
package pvt_pkg;
  typedef enum logic {
    LAYOUT_WAVE  = 1'b0,
    LAYOUT_FIBER = 1'b1
  } layout_e;

  function automatic int safe_clog2(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/pvt_proc_base.sv
module pvt_proc_base #(
  parameter int ADDR_W = 32,
  parameter int PROC_W = 2
) (
  input  logic [PROC_W-1:0] proc_id,
  input  logic [ADDR_W-1:0] proc_size,
  input  logic [ADDR_W-1:0] base_addr,
  output logic [ADDR_W-1:0] proc_term
);
  // Each processor's area is proc_size bytes long, stacked on the base.
  always_comb begin
    proc_term = base_addr + ADDR_W'(proc_id) * proc_size;
  end
endmodule

// File: rtl/pvt_wave_addr.sv
module pvt_wave_addr #(
  parameter int ADDR_W  = 32,
  parameter int OFF_W   = 12,
  parameter int FIBERS  = 128,
  parameter int FIBER_W = 7,
  parameter int WAVE_W  = 4,
  parameter int ITEM_W  = 16
) (
  input  logic [OFF_W-1:0]   byte_off,
  input  logic [FIBER_W-1:0] fiber_id,
  input  logic [WAVE_W-1:0]  wave_id,
  input  logic [ITEM_W-1:0]  item_size,
  input  logic [ADDR_W-1:0]  proc_term,
  output logic [ADDR_W-1:0]  addr
);
  localparam logic [ADDR_W-1:0] LANE_STRIDE = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] DW_STRIDE   = ADDR_W'(FIBERS * 4);
  localparam logic [ADDR_W-1:0] FIBER_CNT   = ADDR_W'(FIBERS);

  logic [ADDR_W-1:0] byte_part;
  logic [ADDR_W-1:0] lane_part;
  logic [ADDR_W-1:0] dword_part;
  logic [ADDR_W-1:0] wave_part;

  // Fastest to slowest: byte in dword, fiber, dword index, wavefront.
  always_comb begin
    byte_part  = ADDR_W'(byte_off[1:0]);
    lane_part  = ADDR_W'(fiber_id) * LANE_STRIDE;
    dword_part = ADDR_W'(byte_off[OFF_W-1:2]) * DW_STRIDE;
    wave_part  = ADDR_W'(wave_id) * (ADDR_W'(item_size) * FIBER_CNT);
    addr       = proc_term + wave_part + dword_part + lane_part + byte_part;
  end
endmodule

// File: rtl/pvt_fiber_addr.sv
module pvt_fiber_addr #(
  parameter int ADDR_W    = 32,
  parameter int OFF_W     = 12,
  parameter int FIBER_W   = 7,
  parameter int NUM_WAVES = 16,
  parameter int WAVE_W    = 4,
  parameter int ITEM_W    = 16
) (
  input  logic [OFF_W-1:0]   byte_off,
  input  logic [FIBER_W-1:0] fiber_id,
  input  logic [WAVE_W-1:0]  wave_id,
  input  logic [ITEM_W-1:0]  item_size,
  input  logic [ADDR_W-1:0]  proc_term,
  output logic [ADDR_W-1:0]  addr
);
  localparam int GROUP_W = FIBER_W - 2;
  localparam bit WAVES_POW2 = ((NUM_WAVES & (NUM_WAVES - 1)) == 0) &&
                              (NUM_WAVES == (1 << WAVE_W));

  logic [1:0]         lane;
  logic [GROUP_W-1:0] group;
  logic [ADDR_W-1:0]  slot;

  assign lane  = fiber_id[1:0];
  assign group = fiber_id[FIBER_W-1:2];

  // Slot order, fastest first: fiber mod 4, wavefront, fiber div 4.
  generate
    if (WAVES_POW2) begin : g_pack
      always_comb begin
        slot = ADDR_W'({group, wave_id, lane});
      end
    end else begin : g_mul
      localparam logic [ADDR_W-1:0] GROUP_STRIDE = ADDR_W'(NUM_WAVES * 4);
      always_comb begin
        slot = ADDR_W'(group) * GROUP_STRIDE
             + ADDR_W'(wave_id) * ADDR_W'(4)
             + ADDR_W'(lane);
      end
    end
  endgenerate

  always_comb begin
    addr = proc_term + slot * ADDR_W'(item_size) + ADDR_W'(byte_off);
  end
endmodule

// File: rtl/pvt_addr_gen.sv
module pvt_addr_gen
  import pvt_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int OFF_W     = 12,
  parameter int FIBERS    = 128,
  parameter int NUM_WAVES = 16,
  parameter int NUM_PROCS = 4,
  parameter int ITEM_W    = 16,
  parameter int LEN_W     = 2,
  localparam int FIBER_W  = safe_clog2(FIBERS),
  localparam int WAVE_W   = safe_clog2(NUM_WAVES),
  localparam int PROC_W   = safe_clog2(NUM_PROCS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic               layout_sel,
  input  logic [LEN_W-1:0]   acc_len,
  input  logic [OFF_W-1:0]   byte_off,
  input  logic [FIBER_W-1:0] fiber_id,
  input  logic [WAVE_W-1:0]  wave_id,
  input  logic [PROC_W-1:0]  proc_id,
  input  logic [ITEM_W-1:0]  item_size,
  input  logic [ADDR_W-1:0]  proc_size,
  input  logic [ADDR_W-1:0]  base_addr,
  output logic               out_valid,
  output logic [ADDR_W-1:0]  addr_out,
  output logic               err_wide
);
  logic [ADDR_W-1:0] proc_term;
  logic [ADDR_W-1:0] wave_addr;
  logic [ADDR_W-1:0] fiber_addr;
  logic              is_wide;
  logic              wide_in_fiber;
  logic [ADDR_W-1:0] next_addr;
  layout_e           layout;

  pvt_proc_base #(.ADDR_W(ADDR_W), .PROC_W(PROC_W)) u_proc (
    .proc_id   (proc_id),
    .proc_size (proc_size),
    .base_addr (base_addr),
    .proc_term (proc_term)
  );

  pvt_wave_addr #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .FIBERS(FIBERS),
    .FIBER_W(FIBER_W), .WAVE_W(WAVE_W), .ITEM_W(ITEM_W)
  ) u_wave (
    .byte_off  (byte_off),
    .fiber_id  (fiber_id),
    .wave_id   (wave_id),
    .item_size (item_size),
    .proc_term (proc_term),
    .addr      (wave_addr)
  );

  pvt_fiber_addr #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .FIBER_W(FIBER_W),
    .NUM_WAVES(NUM_WAVES), .WAVE_W(WAVE_W), .ITEM_W(ITEM_W)
  ) u_fiber (
    .byte_off  (byte_off),
    .fiber_id  (fiber_id),
    .wave_id   (wave_id),
    .item_size (item_size),
    .proc_term (proc_term),
    .addr      (fiber_addr)
  );

  // A wide access cannot use per-fiber slots; it falls back to the wave layout.
  always_comb begin
    layout        = layout_e'(layout_sel);
    is_wide       = (acc_len != '0);
    wide_in_fiber = (layout == LAYOUT_FIBER) && is_wide;
    if (layout == LAYOUT_FIBER && !is_wide) next_addr = fiber_addr;
    else                                    next_addr = wave_addr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      addr_out  <= '0;
      err_wide  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        addr_out <= next_addr;
        err_wide <= wide_in_fiber;
      end
    end
  end
endmodule

// File: rtl/pvt_addr_gen_chk.sv
module pvt_addr_gen_chk #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              layout_sel,
  input logic [LEN_W-1:0]  acc_len,
  input logic              out_valid,
  input logic [ADDR_W-1:0] addr_out,
  input logic              err_wide
);
  logic rst_q = 1'b0;
  always_ff @(posedge clk) rst_q <= rst;

  // R1: outputs are cleared in the cycle after reset
  always @(posedge clk) begin
    if (rst_q) begin
      assert_reset_clear_R1: assert (!out_valid && !err_wide && addr_out == '0)
        else $error("R1 outputs not cleared by reset");
    end
  end

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_idle_no_valid_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  assert_wide_fiber_flag_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && layout_sel && acc_len != '0) |=> err_wide);

  assert_wave_no_flag_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !layout_sel) |=> !err_wide);

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(addr_out) && $stable(err_wide)));
endmodule

bind pvt_addr_gen pvt_addr_gen_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .layout_sel (layout_sel),
  .acc_len    (acc_len),
  .out_valid  (out_valid),
  .addr_out   (addr_out),
  .err_wide   (err_wide)
);

// File: tb/sim_pvt_addr_gen.sv
module sim_pvt_addr_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        layout_sel = 1'b0;
  logic [1:0]  acc_len = '0;
  logic [11:0] byte_off = '0;
  logic [6:0]  fiber_id = '0;
  logic [3:0]  wave_id = '0;
  logic [1:0]  proc_id = '0;
  logic [15:0] item_size = '0;
  logic [31:0] proc_size = '0;
  logic [31:0] base_addr = '0;
  logic        out_valid;
  logic [31:0] addr_out;
  logic        err_wide;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  pvt_addr_gen u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .layout_sel(layout_sel),
    .acc_len(acc_len), .byte_off(byte_off), .fiber_id(fiber_id),
    .wave_id(wave_id), .proc_id(proc_id), .item_size(item_size),
    .proc_size(proc_size), .base_addr(base_addr),
    .out_valid(out_valid), .addr_out(addr_out), .err_wide(err_wide)
  );

  function automatic logic [31:0] ref_wave(int off, int fib, int wav, int prc,
                                           longint item, longint psz, longint base);
    longint s;
    s = base + prc * psz + wav * item * 128 + (off / 4) * 512 + fib * 4 + (off % 4);
    return s[31:0];
  endfunction

  function automatic logic [31:0] ref_fiber(int off, int fib, int wav, int prc,
                                            longint item, longint psz, longint base);
    longint s;
    longint slot;
    slot = (fib / 4) * 64 + wav * 4 + (fib % 4);
    s = base + prc * psz + slot * item + off;
    return s[31:0];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input int lay, input int len, input int off, input int fib,
                       input int wav, input int prc);
    @(negedge clk);
    in_valid   = 1'b1;
    layout_sel = lay[0];
    acc_len    = len[1:0];
    byte_off   = off[11:0];
    fiber_id   = fib[6:0];
    wave_id    = wav[3:0];
    proc_id    = prc[1:0];
    @(negedge clk);
  endtask

  task automatic sweep(input logic [15:0] it, input logic [31:0] ps, input logic [31:0] bs);
    int offs[8] = '{0, 1, 3, 4, 7, 100, 2050, 4095};
    int wavs[4] = '{0, 1, 5, 15};
    item_size = it; proc_size = ps; base_addr = bs;
    for (int lay = 0; lay < 2; lay++)
      for (int prc = 0; prc < 4; prc += 3)
        for (int wi = 0; wi < 4; wi++)
          for (int oi = 0; oi < 8; oi++)
            for (int fib = 0; fib < 128; fib++) begin
              int len;
              logic [31:0] exp_a;
              logic        exp_e;
              len = (fib + wi + oi) % 4;
              apply(lay, len, offs[oi], fib, wavs[wi], prc);
              if (lay == 1 && len == 0) begin
                exp_a = ref_fiber(offs[oi], fib, wavs[wi], prc, it, ps, bs);
                check("R4/R7 fiber address", addr_out, exp_a);
              end else if (lay == 1) begin
                exp_a = ref_wave(offs[oi], fib, wavs[wi], prc, it, ps, bs);
                check("R5 wide fallback address", addr_out, exp_a);
              end else begin
                exp_a = ref_wave(offs[oi], fib, wavs[wi], prc, it, ps, bs);
                check("R3/R6/R7 wave address", addr_out, exp_a);
              end
              exp_e = (lay == 1 && len != 0);
              check("R5/R6 error flag", {31'd0, err_wide}, {31'd0, exp_e});
              check("R2 valid", {31'd0, out_valid}, 32'd1);
            end
  endtask

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    check("R1 valid in reset", {31'd0, out_valid}, 32'd0);
    check("R1 addr in reset", addr_out, 32'd0);
    check("R1 err in reset", {31'd0, err_wide}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 valid after reset", {31'd0, out_valid}, 32'd0);
    check("R1 addr after reset", addr_out, 32'd0);

    sweep(16'h0200, 32'h0010_0000, 32'h0800_0000);
    sweep(16'hFFF0, 32'h4000_0000, 32'hFFFF_0000);

    // R8: a wide fiber request sets the error; idle cycles with changed inputs hold it
    apply(1, 3, 37, 9, 2, 1);
    held = addr_out;
    check("R5 flag before idle", {31'd0, err_wide}, 32'd1);
    @(negedge clk);
    in_valid = 1'b0; layout_sel = 1'b0; acc_len = 2'd0;
    byte_off = 12'd5; fiber_id = 7'd100; wave_id = 4'd7; proc_id = 2'd2;
    repeat (2) @(negedge clk);
    check("R2 idle valid", {31'd0, out_valid}, 32'd0);
    check("R8 addr held", addr_out, held);
    check("R8 err held", {31'd0, err_wide}, 32'd1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule